// File: doc/BRIEF.md
# Serial Peripheral Master with Slave Handshake Gate

This block is a serial peripheral master that moves one 16-bit word per transfer in full duplex. A local client hands it a word with a single-cycle write strobe while the block is idle. The block shifts that word out most significant bit first on `mosi` and shifts the slave's reply in from `miso`. It then presents the received word together with a one-cycle completion strobe. The serial clock runs at the system clock divided by `2*(cfg_div+1)`. It idles at the level chosen by `cfg_cpol`, and `cfg_cpha` selects whether data is captured on the first or the second edge of each bit.

Two options are chosen per transfer. With `cfg_sel_en` set, an active-low select is driven low for the whole transfer, with one half serial period of guard time before the first clock edge and after the last one. With `cfg_hs_en` set, the master parks an accepted word and produces no clock edges until the slave pulls its active-low ready line low. This lets each word start as soon as the slave has actually serviced the previous one, so no fixed worst-case gap is needed between words. The ready line passes through a two-flop synchronizer before use.

Top module: `spi_hs_master`

## Requirements
- R1: After reset, `busy` is 0, `sel_n` is 1, `rx_done` is 0 and `sclk` equals `cfg_cpol`.
- R2: A transfer sends `tx_word` on `mosi` and assembles 16 bits from `miso` into `rx_word`, both most significant bit first.
- R3: `sclk` idles at `cfg_cpol` and makes exactly 32 transitions per transfer. With `cfg_cpha`=0 both ends capture on the first (leading) edge of each bit. With `cfg_cpha`=1 they capture on the second (trailing) edge.
- R4: Each serial half period lasts `cfg_div+1` system clocks (`cfg_div` from 0 to 255). Without the handshake, `busy` stays high for exactly 34*(`cfg_div`+1) cycles.
- R5: With `cfg_sel_en`=1, `sel_n` is low for exactly 34*(`cfg_div`+1) cycles per transfer and never high during a clock transition. With `cfg_sel_en`=0, `sel_n` stays 1.
- R6: With `cfg_hs_en`=1, an accepted word causes no `sclk` transition and no `sel_n` assertion while `rdy_n` is 1, though `busy` is high. The transfer proceeds once `rdy_n` is 0.
- R7: With `cfg_hs_en`=0, a transfer starts at once whatever the level of `rdy_n`.
- R8: A `tx_valid` strobe while `busy` is 1 is ignored. The running word is not altered and no further transfer follows.
- R9: `rx_done` is a one-cycle pulse. It rises in the cycle `busy` falls, with `rx_word` valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_div | input | 8 | Half-period length minus one, in system clocks |
| cfg_sel_en | input | 1 | Drive the active-low select during transfers |
| cfg_hs_en | input | 1 | Wait for slave ready before each word |
| tx_valid | input | 1 | Write strobe for `tx_word`, taken only when idle |
| tx_word | input | 16 | Word to transmit |
| busy | output | 1 | Transfer pending or in progress |
| rx_word | output | 16 | Last received word |
| rx_done | output | 1 | One-cycle completion strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| sel_n | output | 1 | Active-low slave select |
| rdy_n | input | 1 | Active-low slave ready, asynchronous |

## Verification
The bench builds the block with its default parameters: a 16-bit word and an 8-bit divider field. The full 0 to 255 range of `cfg_div` is therefore reachable, and one directed transfer uses the slowest setting of 255. Random transfers keep the divider small so that many of them fit. They cover all four polarity and phase pairs, both select settings and both handshake settings, with the bench acting as the slave for each mode. Directed cases hold the ready line off for a long stretch, strobe a write mid-transfer, and leave the ready line inactive while the handshake is disabled.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_READY,
    ST_ASSERT_CS,
    ST_SHIFT,
    ST_FINISH
  } hs_state_t;
endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hs_div.sv
module spi_hs_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q == div_i);
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/spi_hs_shift.sv
module spi_hs_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              launch_i,
  input  logic              sample_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load_i)        tx_d = load_word_i;
    else if (launch_i) tx_d = {tx_q[WORD_W-2:0], 1'b0};
    if (sample_i)      rx_d = {rx_q[WORD_W-2:0], ser_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign ser_o  = tx_q[WORD_W-1];
  assign word_o = rx_q;
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_sel_en,
  input  logic              cfg_hs_en,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              busy,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              sel_n,
  input  logic              rdy_n
);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic rst_sync_n;
  logic rdy_sync_n;

  spi_hs_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n));

  spi_hs_sync #(.STAGES(2), .RST_VAL(1'b1)) i_rdy_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(rdy_n), .q_o(rdy_sync_n));

  hs_state_t         state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              cpol_q, cpha_q, sel_en_q;
  logic [DIV_W-1:0]  div_q;
  logic              sclk_q, sclk_d;
  logic [WORD_W-1:0] rx_word_q;
  logic              rx_done_q;
  logic              accept, tick, div_en, launch, sample, finish;
  logic [WORD_W-1:0] shift_word;

  assign accept = (state_q == ST_IDLE) && tx_valid;
  assign div_en = (state_q == ST_ASSERT_CS) || (state_q == ST_SHIFT) ||
                  (state_q == ST_FINISH);
  assign finish = (state_q == ST_FINISH) && tick;

  spi_hs_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_sync_n), .en_i(div_en), .div_i(div_q), .tick_o(tick));

  // Edge index: even = leading, odd = trailing.
  always_comb begin
    launch = 1'b0;
    sample = 1'b0;
    if ((state_q == ST_SHIFT) && tick) begin
      sample = (edge_q[0] == cpha_q);
      if (cpha_q) launch = !edge_q[0] && (edge_q != '0);
      else        launch = edge_q[0];
    end
  end

  spi_hs_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_sync_n), .load_i(accept), .load_word_i(tx_word),
    .launch_i(launch), .sample_i(sample), .ser_i(miso), .ser_o(mosi),
    .word_o(shift_word));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (tx_valid) state_d = cfg_hs_en ? ST_WAIT_READY : ST_ASSERT_CS;
      ST_WAIT_READY: if (!rdy_sync_n) state_d = ST_ASSERT_CS;
      ST_ASSERT_CS:  if (tick) state_d = ST_SHIFT;
      ST_SHIFT:      if (tick && edge_q == LAST_EDGE) state_d = ST_FINISH;
      ST_FINISH:     if (tick) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    edge_d = '0;
    if (state_q == ST_SHIFT) edge_d = tick ? edge_q + 1'b1 : edge_q;
    sclk_d = sclk_q;
    if (state_q == ST_IDLE)                sclk_d = cfg_cpol;
    else if ((state_q == ST_SHIFT) && tick) sclk_d = !sclk_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      edge_q    <= '0;
      sclk_q    <= 1'b0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      sel_en_q  <= 1'b0;
      div_q     <= '0;
      rx_word_q <= '0;
      rx_done_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      edge_q    <= edge_d;
      sclk_q    <= sclk_d;
      rx_done_q <= finish;
      if (accept) begin
        cpol_q   <= cfg_cpol;
        cpha_q   <= cfg_cpha;
        sel_en_q <= cfg_sel_en;
        div_q    <= cfg_div;
      end
      if (finish) rx_word_q <= shift_word;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign sclk    = rst_sync_n ? sclk_q : cfg_cpol;
  assign sel_n   = !(sel_en_q && div_en);
  assign rx_word = rx_word_q;
  assign rx_done = rx_done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_done |=> !rx_done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_done |-> !busy);
  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_WAIT_READY) |=> $stable(sclk_q));
  // R5
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> sel_n);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_FINISH) && tick) |=> (sclk_q == cpol_q));
endmodule

// File: tb/test_spi_hs_master.sv
module test_spi_hs_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_sel_en = 1'b0, cfg_hs_en = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic tx_valid = 1'b0;
  logic [15:0] tx_word = 16'd0;
  logic miso = 1'b0, rdy_n = 1'b1;
  logic busy, rx_done, sclk, mosi, sel_n;
  logic [15:0] rx_word;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_hs_master i_spi_hs_master (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_sel_en(cfg_sel_en), .cfg_hs_en(cfg_hs_en),
    .tx_valid(tx_valid), .tx_word(tx_word), .busy(busy), .rx_word(rx_word),
    .rx_done(rx_done), .sclk(sclk), .mosi(mosi), .miso(miso), .sel_n(sel_n),
    .rdy_n(rdy_n));

  // bench-side slave model and monitors
  logic [15:0] slv_word, slv_rx;
  int slv_idx, tgl_cnt, sel_cnt, busy_cnt, sel_viol;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (!sel_n) sel_cnt++;
    if (sclk !== prev_sclk) begin
      if (busy) begin
        logic lead;
        tgl_cnt++;
        if (cfg_sel_en && sel_n) sel_viol++;
        lead = (sclk != cfg_cpol);
        if (lead == !cfg_cpha) slv_rx = {slv_rx[14:0], mosi};
        else if (!cfg_cpha) begin
          slv_idx--;
          if (slv_idx >= 0) miso = slv_word[slv_idx];
        end else begin
          if (slv_idx >= 0) miso = slv_word[slv_idx];
          slv_idx--;
        end
      end
      prev_sclk = sclk;
    end
  end

  function automatic int exp_busy(input logic [7:0] d);
    return 34 * (int'(d) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input logic [7:0] d,
                      input bit sel_en, input bit hs_en, input logic [15:0] tx,
                      input logic [15:0] slv, input int hold, input bit inject,
                      input bit rdy_idle);
    int n;
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_div = d;
    cfg_sel_en = sel_en; cfg_hs_en = hs_en;
    rdy_n = hs_en ? 1'b1 : rdy_idle;
    repeat (3) @(negedge clk);
    slv_word = slv; slv_idx = 15; slv_rx = '0;
    miso = cpha ? 1'b0 : slv[15];
    tgl_cnt = 0; sel_cnt = 0; busy_cnt = 0; sel_viol = 0;
    tx_valid = 1'b1; tx_word = tx;
    @(negedge clk);
    tx_valid = 1'b0;
    if (hs_en) begin
      repeat (hold) @(negedge clk);
      chk(tgl_cnt == 0, "R6", "edges while not ready", tgl_cnt, 0);
      chk(sel_cnt == 0, "R6", "select while not ready", sel_cnt, 0);
      chk(busy == 1'b1, "R6", "busy while waiting", busy, 1);
      rdy_n = 1'b0;
    end
    if (inject) begin
      repeat (40) @(negedge clk);
      tx_valid = 1'b1; tx_word = ~tx;
      @(negedge clk);
      tx_valid = 1'b0;
    end
    n = 0;
    while (!rx_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(rx_done == 1'b1, "R9", "done seen", rx_done, 1);
    chk(rx_word == slv, "R2", "received word", rx_word, slv);
    chk(slv_rx == tx, "R2", "slave got word", slv_rx, tx);
    chk(tgl_cnt == 32, "R3", "clock transitions", tgl_cnt, 32);
    chk(sclk == cpol, "R3", "idle level after", sclk, cpol);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    chk(sel_cnt == (sel_en ? exp_busy(d) : 0), "R5", "select low cycles",
        sel_cnt, sel_en ? exp_busy(d) : 0);
    chk(sel_viol == 0, "R5", "edge with select high", sel_viol, 0);
    if (!hs_en)
      chk(busy_cnt == exp_busy(d), "R4", "busy cycles", busy_cnt, exp_busy(d));
    @(negedge clk);
    chk(rx_done == 1'b0, "R9", "done one cycle", rx_done, 0);
    if (inject) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R8", "no transfer from busy write", busy, 0);
      chk(rx_word == slv, "R8", "word kept", rx_word, slv);
    end
    rdy_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(sel_n == 1'b1, "R1", "select after reset", sel_n, 1);
    chk(rx_done == 1'b0, "R1", "done after reset", rx_done, 0);
    chk(sclk == cfg_cpol, "R1", "clock level after reset", sclk, cfg_cpol);

    xfer(0, 0, 8'd0, 1, 0, 16'hA5C3, 16'h3C5A, 0, 0, 1);   // mode 0, fastest
    xfer(1, 1, 8'd255, 1, 0, 16'h8001, 16'h7FFE, 0, 0, 1); // slowest divide
    xfer(0, 1, 8'd3, 1, 1, 16'h1234, 16'hFEDC, 60, 0, 1);  // R6 long hold
    xfer(1, 0, 8'd2, 0, 0, 16'hFFFF, 16'h0000, 0, 0, 1);   // R7 ready high ignored
    xfer(0, 0, 8'd4, 1, 0, 16'h0F0F, 16'hC0DE, 0, 1, 0);   // R8 busy write

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom;
      xfer(r[0], r[1], 8'($urandom_range(0, 5)), r[2], r[3],
           16'($urandom), 16'($urandom), int'($urandom_range(1, 20)), 0, r[4]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule